// File: doc/BRIEF.md
# Write-Data Parity Check and Poison Stage

This stage sits in the write-data path ahead of the memory controller. Each 64-bit beat arrives with eight even-parity bits, one per byte lane. The stage recomputes the parity of the data, compares it with the parity that came in, and sends the beat on one cycle later with parity it has generated itself. A beat whose parity check failed is treated in one of two ways, chosen by a single enable bit in a 32-bit control word. With poisoning off, the beat leaves with clean parity, which hides the error from the consumer. With poisoning on, the beat leaves with every parity bit inverted, so any later checker sees it as corrupt.

A detected error can also raise a one-cycle interrupt pulse, gated by an enable input and a mask input. An injection request arms a one-shot that poisons the parity of the next accepted beat, whatever the poison-enable setting is. Errors never stall the data flow, because the handshake depends only on the output side.

Top module: `par_poison_path`

## Requirements
- R1: After reset the control word reads 32'h0000_0000, poisoning is off, out_valid_o is 0, err_irq_o is 0 and in_ready_o is 1.
- R2: The poison enable is bit 18 of the control word. A write with cfg_we_i stores cfg_wdata_i[18]. All other bits read as zero and writes to them are ignored, so writing 32'hFFFF_FFFF reads back 32'h0004_0000.
- R3: Parity is even per byte lane: the good parity bit k is the XOR of in_data_i[8k+7:8k]. A beat is in error when any bit of in_par_i differs from its good value.
- R4: With poisoning off, an erroneous beat leaves with its data unchanged and with the good parity of that data.
- R5: With poisoning on, an erroneous beat leaves with all eight good parity bits inverted.
- R6: A beat without error and without injection leaves with its good parity in either mode.
- R7: err_irq_o is high for exactly the one cycle after an erroneous beat is accepted, and only if irq_en_i was 1 and irq_mask_i was 0 in the cycle of acceptance. This holds in both modes.
- R8: A one-cycle inj_req_i arms an injection. The first beat accepted in that cycle or later leaves with all parity bits inverted, in either mode, and the injection then disarms. An injection alone raises no interrupt. A beat that is both erroneous and injected is inverted only once.
- R9: A beat accepted at a clock edge is on the output (out_valid_o=1) after that edge. in_ready_o = !out_valid_o || out_ready_i, so errors never throttle the flow, and back-to-back beats stream at one per cycle.
- R10: While out_valid_o=1 and out_ready_i=0, the output beat (valid, data and parity) holds unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Control word write strobe |
| cfg_wdata_i | input | 32 | Control word write data |
| cfg_rdata_o | output | 32 | Control word read value |
| irq_en_i | input | 1 | Interrupt enable |
| irq_mask_i | input | 1 | Interrupt mask (1 = masked) |
| inj_req_i | input | 1 | Error injection request pulse |
| in_valid_i | input | 1 | Input beat valid |
| in_ready_o | output | 1 | Input beat ready |
| in_data_i | input | 64 | Input data |
| in_par_i | input | 8 | Input parity, one bit per byte |
| out_valid_o | output | 1 | Output beat valid |
| out_ready_i | input | 1 | Output beat ready |
| out_data_o | output | 64 | Output data |
| out_par_o | output | 8 | Output parity (good or poisoned) |
| err_irq_o | output | 1 | Error interrupt pulse |

## Verification
The bench targets the interactions between modes.

- **Injection with poisoning off.** The beat must still come out inverted. A design that gates injection with the enable would forward clean parity.
- **Injection on an erroneous beat with poisoning on.** The parity must be inverted exactly once. A design that inverts twice would emit good parity.
- **Injection in the cycle of acceptance.** The bench requests an injection in the same cycle a beat is accepted and then checks that only one beat is poisoned. A design that never clears the one-shot would poison every later beat.
- **Interrupt gating.** All four combinations of enable and mask are exercised.
- **Output stalls.** Random ready patterns and error-dense bursts at full rate expose any data change under backpressure and any throttling caused by errors.

// File: rtl/par_pkg.sv
package par_pkg;
  localparam int unsigned LANE_W     = 8;
  localparam int unsigned CTL_W      = 32;
  localparam int unsigned POISON_BIT = 18;
  localparam logic [CTL_W-1:0] CTL_MASK = CTL_W'(1) << POISON_BIT;
endpackage

// File: rtl/par_lane_gen.sv
module par_lane_gen #(
  parameter int unsigned DATA_W = 64,
  localparam int unsigned PAR_W = DATA_W / par_pkg::LANE_W
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [PAR_W-1:0]  par_i,
  output logic [PAR_W-1:0]  par_good_o,
  output logic              err_o
);
  for (genvar k = 0; k < PAR_W; k++) begin : g_lane
    assign par_good_o[k] = ^data_i[k*par_pkg::LANE_W +: par_pkg::LANE_W];
  end
  assign err_o = |(par_good_o ^ par_i);
endmodule

// File: rtl/par_ctl_reg.sv
module par_ctl_reg (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [par_pkg::CTL_W-1:0]   wdata_i,
  output logic [par_pkg::CTL_W-1:0]   rdata_o,
  output logic                        poison_en_o
);
  import par_pkg::*;
  logic [CTL_W-1:0] ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctl_q <= '0;
    else if (we_i) ctl_q <= wdata_i & CTL_MASK;
  end

  assign rdata_o     = ctl_q;
  assign poison_en_o = ctl_q[POISON_BIT];

  // R2
  ctl_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (poison_en_o == $past(wdata_i[POISON_BIT])));
endmodule

// File: rtl/par_inj_arm.sv
module par_inj_arm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic fire_i,
  output logic apply_o
);
  logic pend_q;

  // request in the accepting cycle applies to that beat
  assign apply_o = pend_q | req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_q <= 1'b0;
    else if (fire_i) pend_q <= 1'b0;
    else if (req_i)  pend_q <= 1'b1;
  end

  // R8
  inj_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> !pend_q);
endmodule

// File: rtl/par_pipe_stage.sv
module par_pipe_stage #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned PAR_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic [PAR_W-1:0]  in_par_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic [PAR_W-1:0]  out_par_o
);
  logic              vld_q;
  logic [DATA_W-1:0] dat_q;
  logic [PAR_W-1:0]  par_q;
  logic              fire;

  assign in_ready_o = !vld_q || out_ready_i;
  assign fire       = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          vld_q <= 1'b0;
    else if (fire)        vld_q <= 1'b1;
    else if (out_ready_i) vld_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dat_q <= '0;
      par_q <= '0;
    end else if (fire) begin
      dat_q <= in_data_i;
      par_q <= in_par_i;
    end
  end

  assign out_valid_o = vld_q;
  assign out_data_o  = dat_q;
  assign out_par_o   = par_q;

  // R9
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> out_valid_o);
  // R10
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(out_data_o) && $stable(out_par_o)));
endmodule

// File: rtl/par_poison_path.sv
module par_poison_path #(
  parameter int unsigned DATA_W = 64,
  localparam int unsigned PAR_W = DATA_W / par_pkg::LANE_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      cfg_we_i,
  input  logic [par_pkg::CTL_W-1:0] cfg_wdata_i,
  output logic [par_pkg::CTL_W-1:0] cfg_rdata_o,
  input  logic                      irq_en_i,
  input  logic                      irq_mask_i,
  input  logic                      inj_req_i,
  input  logic                      in_valid_i,
  output logic                      in_ready_o,
  input  logic [DATA_W-1:0]         in_data_i,
  input  logic [PAR_W-1:0]          in_par_i,
  output logic                      out_valid_o,
  input  logic                      out_ready_i,
  output logic [DATA_W-1:0]         out_data_o,
  output logic [PAR_W-1:0]          out_par_o,
  output logic                      err_irq_o
);
  logic             poison_en;
  logic [PAR_W-1:0] par_good;
  logic [PAR_W-1:0] par_fwd;
  logic             par_err;
  logic             inj_apply;
  logic             fire;
  logic             corrupt;
  logic             irq_q;

  par_ctl_reg u_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (cfg_we_i),
    .wdata_i     (cfg_wdata_i),
    .rdata_o     (cfg_rdata_o),
    .poison_en_o (poison_en)
  );

  par_lane_gen #(.DATA_W(DATA_W)) u_chk (
    .data_i     (in_data_i),
    .par_i      (in_par_i),
    .par_good_o (par_good),
    .err_o      (par_err)
  );

  assign fire = in_valid_i && in_ready_o;

  par_inj_arm u_inj (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (inj_req_i),
    .fire_i  (fire),
    .apply_o (inj_apply)
  );

  // one inversion even when both causes hold
  assign corrupt = (par_err && poison_en) || inj_apply;
  assign par_fwd = par_good ^ {PAR_W{corrupt}};

  par_pipe_stage #(.DATA_W(DATA_W), .PAR_W(PAR_W)) u_pipe (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_ready_o  (in_ready_o),
    .in_data_i   (in_data_i),
    .in_par_i    (par_fwd),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .out_data_o  (out_data_o),
    .out_par_o   (out_par_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= fire && par_err && irq_en_i && !irq_mask_i;
  end
  assign err_irq_o = irq_q;

  // R7
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_irq_o |-> $past(irq_en_i && !irq_mask_i && in_valid_i));
endmodule

// File: tb/sim_par_poison_path.sv
module sim_par_poison_path;
  typedef struct packed {
    logic [63:0] d;
    logic [7:0]  p;
    logic [3:0]  rq;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        irq_en = 1'b0, irq_mask = 1'b0, inj_req = 1'b0;
  logic        in_valid = 1'b0, in_ready;
  logic [63:0] in_data = '0;
  logic [7:0]  in_par = '0;
  logic        out_valid, out_ready = 1'b1;
  logic [63:0] out_data;
  logic [7:0]  out_par;
  logic        err_irq;

  int total = 0, bad = 0;
  exp_t sb[$];
  bit   m_poison = 0, m_pend = 0;
  bit   stall_mode = 0;

  always #5 clk = ~clk;

  par_poison_path u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .irq_en_i(irq_en), .irq_mask_i(irq_mask), .inj_req_i(inj_req),
    .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_data_i(in_data), .in_par_i(in_par),
    .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_data_o(out_data), .out_par_o(out_par), .err_irq_o(err_irq)
  );

  function automatic logic [7:0] gpar(logic [63:0] d);
    logic [7:0] p;
    for (int k = 0; k < 8; k++) p[k] = ^d[k*8 +: 8];
    return p;
  endfunction

  task automatic chk(int rq, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // ready pattern for stall phases
  always @(posedge clk) begin
    #1;
    if (stall_mode) out_ready = ($urandom_range(0, 2) != 0);
    else            out_ready = 1'b1;
  end

  // monitor: pop and compare on each output handshake
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      exp_t e;
      total++;
      if (sb.size() == 0) begin
        bad++;
        $display("FAIL R9 actual=unexpected beat %h expected=none", out_data);
      end else begin
        e = sb.pop_front();
        chk(32'(e.rq), out_data, e.d);
        chk(32'(e.rq), {56'h0, out_par}, {56'h0, e.p});
      end
    end
  end

  // driver: time is 1ns after a posedge on entry and exit
  task automatic send(logic [63:0] d, logic [7:0] flip, int rq, bit chk_rdy);
    bit err;
    bit corrupt;
    exp_t e;
    in_data  = d;
    in_par   = gpar(d) ^ flip;
    in_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (chk_rdy) chk(9, {63'h0, in_ready}, 64'h1); // R9 no throttle
      if (in_ready) break;
      @(posedge clk); #1;
    end
    err     = (flip != 0);
    corrupt = (err && m_poison) || m_pend || inj_req;
    e.d  = d;
    e.p  = gpar(d) ^ {8{corrupt}};
    e.rq = 4'(rq);
    @(posedge clk); #1;
    sb.push_back(e);
    m_pend = 0;
    // R7 interrupt pulse one cycle after acceptance
    chk(7, {63'h0, err_irq}, {63'h0, err && irq_en && !irq_mask});
    in_valid = 1'b0;
  endtask

  task automatic wr_cfg(logic [31:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    m_poison = v[18];
  endtask

  task automatic inject();
    inj_req = 1'b1;
    @(posedge clk); #1;
    inj_req = 1'b0;
    m_pend = 1;
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && sb.size() != 0; i++) @(posedge clk);
    #1;
    chk(9, 64'(sb.size()), 64'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(1, {32'h0, cfg_rdata}, 64'h0);
    chk(1, {63'h0, out_valid}, 64'h0);
    chk(1, {63'h0, err_irq}, 64'h0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(1, {63'h0, in_ready}, 64'h1);

    // R2 only bit 18 sticks
    wr_cfg(32'hFFFF_FFFF);
    chk(2, {32'h0, cfg_rdata}, 64'h0004_0000);
    wr_cfg(32'h0000_0000);
    chk(2, {32'h0, cfg_rdata}, 64'h0);
    wr_cfg(32'hFFFB_FFFF);
    chk(2, {32'h0, cfg_rdata}, 64'h0);

    irq_en = 1'b1; irq_mask = 1'b0;
    // R3 R6 good beats, R4 error fixed with poisoning off
    send(64'h0123_4567_89AB_CDEF, 8'h00, 6, 0);
    send(64'hFFFF_0000_A5A5_5A5A, 8'h08, 4, 0);
    send(64'h0000_0000_0000_0001, 8'h81, 4, 0);
    drain();

    // R5 poisoning on
    wr_cfg(32'h0004_0000);
    chk(2, {32'h0, cfg_rdata}, 64'h0004_0000);
    send(64'hDEAD_BEEF_CAFE_F00D, 8'h01, 5, 0);
    send(64'h1122_3344_5566_7788, 8'h00, 6, 0);
    send(64'h8000_0000_0000_0000, 8'hFF, 5, 0);
    drain();

    // R7 gating combinations
    irq_mask = 1'b1;
    send(64'h0F0F_0F0F_0F0F_0F0F, 8'h10, 7, 0);
    irq_en = 1'b0; irq_mask = 1'b0;
    send(64'hF0F0_F0F0_F0F0_F0F0, 8'h20, 7, 0);
    irq_mask = 1'b1;
    send(64'h3333_3333_3333_3333, 8'h40, 7, 0);
    irq_en = 1'b1; irq_mask = 1'b0;
    send(64'h5555_5555_5555_5555, 8'h02, 7, 0);
    drain();

    // R8 injection with poisoning off, then disarmed
    wr_cfg(32'h0);
    inject();
    send(64'hAAAA_BBBB_CCCC_DDDD, 8'h00, 8, 0);
    send(64'h1234_5678_9ABC_DEF0, 8'h00, 8, 0);
    // R8 injection on an error beat with poisoning on: single inversion
    wr_cfg(32'h0004_0000);
    inject();
    send(64'h0BAD_0BAD_0BAD_0BAD, 8'h04, 8, 0);
    send(64'h0BAD_0BAD_0BAD_0BAE, 8'h00, 8, 0);
    // R8 request in the accepting cycle
    inj_req = 1'b1;
    send(64'h7777_6666_5555_4444, 8'h00, 8, 0);
    inj_req = 1'b0;
    send(64'h7777_6666_5555_4445, 8'h00, 8, 0);
    drain();

    // R9 full-rate burst with dense errors: no throttling
    wr_cfg(32'h0);
    for (int i = 0; i < 24; i++)
      send({$urandom, $urandom}, (i % 2 == 0) ? 8'(1 << (i % 8)) : 8'h00, 9, 1);
    drain();

    // R10 random backpressure
    stall_mode = 1;
    wr_cfg(32'h0004_0000);
    for (int i = 0; i < 60; i++) begin
      if (i % 13 == 5) inject();
      send({$urandom, $urandom}, (i % 3 == 0) ? 8'($urandom) | 8'h01 : 8'h00, 10, 0);
    end
    stall_mode = 0;
    drain();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule